// File: doc/BRIEF.md
# Level-Interrupt Acknowledge Controller with Storm Deferral

This block sits beside a table of interrupt input pins and handles the end-of-interrupt side of level-triggered delivery. An end-of-interrupt vector reaches it on one of two paths: a broadcast strobe from the processor side, or a write to a direct acknowledge register. Each pin is configured as level or edge triggered. A pin takes part only if it is level triggered, its configured vector matches, and its in-service flag is set. For each such pin the block clears the in-service flag. It then decides whether a fresh delivery scan must be requested.

A level input can stay asserted while software keeps acknowledging it. The block counts such back-to-back acknowledgements per pin. As long as the count is below a storm limit, it asks for a scan on the next cycle. When the count reaches the limit, the count restarts and the re-delivery is pushed out by a programmable number of cycles on one shared timer. With the defaults (10000 acknowledgements, 500000 cycles) this is one hundredth of a second at 50 MHz. The timer's expiry raises a separate one-cycle scan request.

The service engine that emits messages sits outside this block. It sets the in-service flags and owns the pending-bit writes. It reads entry fields back through a select port.

Top module: `eoi_storm_ctl`

## Requirements
- R1: A pin is affected by an acknowledge only if its vector equals the acknowledged vector, its trigger bit is 1 (level; 0 means edge) and its in-service flag is 1. Every other pin keeps its in-service flag and its count.
- R2: An affected pin reads back an in-service flag of 0 from the cycle after the acknowledge. If `rirr_set` sets that pin's flag in the same cycle, the flag stays 1.
- R3: An affected pin that is unmasked (mask bit 0) and has its pending bit at 1 advances its acknowledge count by one. Otherwise the count returns to zero.
- R4: When an advanced count stays below `STORM_LIMIT`, `svc_now` pulses high for one cycle, one clock edge after the acknowledge is taken. A masked or non-pending affected pin raises no `svc_now`.
- R5: When an advanced count reaches `STORM_LIMIT`, that acknowledge raises no `svc_now`. The count returns to zero, and `svc_late` pulses for one cycle `DEFER_CYCLES` edges after the edge that took the acknowledge.
- R6: Writing a pin's entry (vector, trigger bit, mask bit) zeroes that pin's count and leaves its in-service flag unchanged.
- R7: A direct acknowledge write counts only when all four byte enables are 1, `cfg_version` equals 8'h20 and data bits 31:8 are zero. Data bits 7:0 carry the vector. When a broadcast and a direct write arrive in the same cycle, the broadcast is taken and the direct write is dropped.
- R8: A deferral requested while the timer is already running is dropped, so the earlier expiry stands and only one `svc_late` pulse results.
- R9: While `rst_n` is low at a clock edge, all entries, flags, counts, pending bits, the timer and both request outputs clear to zero.
- R10: `rd_vec`, `rd_level`, `rd_mask` and `rd_rirr` show the entry and flag of the pin chosen by `rd_sel` in the same cycle. `pend_q` shows the pending bits last written with `pend_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bc_eoi_vld | input | 1 | Broadcast acknowledge strobe |
| bc_eoi_vec | input | 8 | Broadcast acknowledged vector |
| dir_eoi_wr | input | 1 | Direct acknowledge register write strobe |
| dir_eoi_be | input | 4 | Byte enables of the direct write |
| dir_eoi_data | input | 32 | Data of the direct write |
| cfg_version | input | 8 | Configured block version |
| ent_wr | input | 1 | Entry write strobe |
| ent_wsel | input | SEL_W | Pin index of the entry write |
| ent_wvec | input | 8 | Vector to write |
| ent_wlevel | input | 1 | Trigger bit to write (1 level, 0 edge) |
| ent_wmask | input | 1 | Mask bit to write (1 masked) |
| rirr_set | input | NUM_PINS | Per-pin in-service set from the service engine |
| pend_wr | input | 1 | Pending-bit write strobe |
| pend_wdata | input | NUM_PINS | Pending bits to write |
| rd_sel | input | SEL_W | Pin index for readback |
| rd_vec | output | 8 | Vector of the selected pin |
| rd_level | output | 1 | Trigger bit of the selected pin |
| rd_mask | output | 1 | Mask bit of the selected pin |
| rd_rirr | output | 1 | In-service flag of the selected pin |
| pend_q | output | NUM_PINS | Pending bits |
| svc_now | output | 1 | Immediate scan request pulse |
| svc_late | output | 1 | Deferred scan request pulse |

## Verification
The bench drives a pin through a full storm. Three immediate requests come before the deferral, so a design that compares the count before advancing it would defer one acknowledge early. A design that ignored entry writes would defer too early in a different place. A second storm lands while the timer is still running. A design that reloads the timer would move the late pulse or produce two of them, and the scoreboard sees an unexpected or missing pulse. The bench also covers:
- edge-triggered pins, vector mismatches and masked or non-pending pins, where a loose match would clear flags or raise requests that should not occur;
- direct writes with partial byte enables, the wrong version or nonzero upper data, each of which must leave the in-service flag set;
- a set-and-clear collision on one flag, which a design with the wrong priority would lose.

// File: rtl/eoi_pkg.sv
// Shared types for the acknowledge controller.
// Assumes an 8-bit vector space throughout the block.
package eoi_pkg;
    localparam int VEC_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        trig_e            trig;
        logic             mask;
    } pin_entry_t;
endpackage

// File: rtl/eoi_src_sel.sv
// Merges the two acknowledge sources into one vector strobe.
// Assumes at most one acknowledge per cycle is consumed; broadcast wins.
module eoi_src_sel
    import eoi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bc_vld,
    input  logic [VEC_W-1:0] bc_vec,
    input  logic             dir_wr,
    input  logic [3:0]       dir_be,
    input  logic [31:0]      dir_data,
    input  logic [7:0]       version,
    output logic             eoi_vld,
    output logic [VEC_W-1:0] eoi_vec
);
    localparam logic [7:0] ACK_REG_VERSION = 8'h20;

    logic dir_ok;

    // Qualify the direct write: full word, right version, vector-sized value.
    always_comb begin
        dir_ok = dir_wr && (dir_be == 4'hF) && (version == ACK_REG_VERSION)
                 && (dir_data[31:VEC_W] == '0);
    end

    // Select the source, broadcast first.
    always_comb begin
        eoi_vld = bc_vld || dir_ok;
        eoi_vec = bc_vld ? bc_vec : dir_data[VEC_W-1:0];
    end

    // R7
    dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_vld && dir_wr && (dir_be != 4'hF)) |-> !eoi_vld);
endmodule

// File: rtl/eoi_pin_slot.sv
// One pin: entry fields, in-service flag and storm count.
// Assumes the acknowledge strobe is at most one cycle per acknowledge and
// that rirr_set comes from the service engine after a delivery.
module eoi_pin_slot
    import eoi_pkg::*;
#(
    parameter int STORM_LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_vld,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             ent_we,
    input  pin_entry_t       ent_wdata,
    input  logic             rirr_set,
    input  logic             pend,
    output pin_entry_t       ent_o,
    output logic             rirr_o,
    output logic             now_o,
    output logic             storm_o
);
    localparam int CNT_W = $clog2(STORM_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(STORM_LIMIT);

    pin_entry_t       ent_q;
    logic             rirr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;
    logic             live;

    // Decide whether this pin takes the acknowledge and what it asks for.
    always_comb begin
        hit     = eoi_vld && (ent_q.vec == eoi_vec) && (ent_q.trig == TRIG_LEVEL) && rirr_q;
        live    = !ent_q.mask && pend;
        cnt_inc = cnt_q + 1'b1;
        storm_o = hit && live && (cnt_inc >= LIM);
        now_o   = hit && live && (cnt_inc < LIM);
    end

    // Hold the entry fields, the in-service flag and the storm count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q  <= '0;
            rirr_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (ent_we) ent_q <= ent_wdata;
            if (rirr_set)  rirr_q <= 1'b1;
            else if (hit)  rirr_q <= 1'b0;
            if (ent_we)    cnt_q <= '0;
            else if (hit)  cnt_q <= now_o ? cnt_inc : '0;
        end
    end

    assign ent_o  = ent_q;
    assign rirr_o = rirr_q;

    // R1
    rirr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_vld && !rirr_set) |=> $stable(rirr_q));
    // R2
    rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !rirr_set) |=> !rirr_q);
    // R6
    cnt_wr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_we |=> (cnt_q == '0));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < LIM);
endmodule

// File: rtl/eoi_defer_timer.sv
// Shared deferral timer: loads DEFER_CYCLES when armed while idle and
// pulses fire_o once on expiry. Arming while running is dropped.
module eoi_defer_timer #(
    parameter int DEFER_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire_o
);
    localparam int TMR_W = $clog2(DEFER_CYCLES + 1);
    localparam logic [TMR_W-1:0] LOAD = TMR_W'(DEFER_CYCLES);

    logic [TMR_W-1:0] tmr_q;
    logic             fire_q;

    // Count down while running; start only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            fire_q <= 1'b0;
        end else if (tmr_q != '0) begin
            tmr_q  <= tmr_q - 1'b1;
            fire_q <= (tmr_q == TMR_W'(1));
        end else begin
            tmr_q  <= arm ? LOAD : '0;
            fire_q <= 1'b0;
        end
    end

    assign fire_o = fire_q;

    // R8
    rearm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));
    // R5
    late_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
endmodule

// File: rtl/eoi_storm_ctl.sv
// Top: per-pin acknowledge handling with storm deferral.
// Assumes the service engine outside sets in-service flags and pending bits.
module eoi_storm_ctl
    import eoi_pkg::*;
#(
    parameter  int NUM_PINS     = 24,
    parameter  int STORM_LIMIT  = 10000,
    parameter  int DEFER_CYCLES = 500000,
    localparam int SEL_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bc_eoi_vld,
    input  logic [VEC_W-1:0]    bc_eoi_vec,
    input  logic                dir_eoi_wr,
    input  logic [3:0]          dir_eoi_be,
    input  logic [31:0]         dir_eoi_data,
    input  logic [7:0]          cfg_version,
    input  logic                ent_wr,
    input  logic [SEL_W-1:0]    ent_wsel,
    input  logic [VEC_W-1:0]    ent_wvec,
    input  logic                ent_wlevel,
    input  logic                ent_wmask,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic                pend_wr,
    input  logic [NUM_PINS-1:0] pend_wdata,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [VEC_W-1:0]    rd_vec,
    output logic                rd_level,
    output logic                rd_mask,
    output logic                rd_rirr,
    output logic [NUM_PINS-1:0] pend_q,
    output logic                svc_now,
    output logic                svc_late
);
    logic             eoi_vld;
    logic [VEC_W-1:0] eoi_vec;
    pin_entry_t       wdata;
    pin_entry_t       ent_arr [NUM_PINS];
    logic [NUM_PINS-1:0] rirr_vec, now_vec, storm_vec;
    logic [NUM_PINS-1:0] pend_r;
    logic             now_r;

    eoi_src_sel u_src (
        .clk(clk), .rst_n(rst_n),
        .bc_vld(bc_eoi_vld), .bc_vec(bc_eoi_vec),
        .dir_wr(dir_eoi_wr), .dir_be(dir_eoi_be), .dir_data(dir_eoi_data),
        .version(cfg_version),
        .eoi_vld(eoi_vld), .eoi_vec(eoi_vec)
    );

    // Pack the entry write fields.
    always_comb begin
        wdata.vec  = ent_wvec;
        wdata.trig = ent_wlevel ? TRIG_LEVEL : TRIG_EDGE;
        wdata.mask = ent_wmask;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        eoi_pin_slot #(.STORM_LIMIT(STORM_LIMIT)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .eoi_vld(eoi_vld), .eoi_vec(eoi_vec),
            .ent_we(ent_wr && (ent_wsel == SEL_W'(p))),
            .ent_wdata(wdata),
            .rirr_set(rirr_set[p]),
            .pend(pend_r[p]),
            .ent_o(ent_arr[p]),
            .rirr_o(rirr_vec[p]),
            .now_o(now_vec[p]),
            .storm_o(storm_vec[p])
        );
    end

    eoi_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .arm(|storm_vec),
        .fire_o(svc_late)
    );

    // Hold the pending bits and register the immediate scan request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r <= '0;
            now_r  <= 1'b0;
        end else begin
            if (pend_wr) pend_r <= pend_wdata;
            now_r <= |now_vec;
        end
    end

    // Read back the selected pin.
    always_comb begin
        rd_vec   = '0;
        rd_level = 1'b0;
        rd_mask  = 1'b0;
        rd_rirr  = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_vec   = ent_arr[i].vec;
                rd_level = (ent_arr[i].trig == TRIG_LEVEL);
                rd_mask  = ent_arr[i].mask;
                rd_rirr  = rirr_vec[i];
            end
        end
    end

    assign pend_q  = pend_r;
    assign svc_now = now_r;

    // R4
    now_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_r |-> $past(eoi_vld));
    // R4
    now_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_vld |=> !now_r);
endmodule

// File: tb/tb_eoi_storm_ctl.sv
module tb_eoi_storm_ctl;
    localparam int NP  = 4;
    localparam int LIM = 4;
    localparam int DLY = 20;
    localparam int SW  = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic           rst_n = 1'b0;
    logic           bc_eoi_vld = 1'b0;
    logic [7:0]     bc_eoi_vec = '0;
    logic           dir_eoi_wr = 1'b0;
    logic [3:0]     dir_eoi_be = '0;
    logic [31:0]    dir_eoi_data = '0;
    logic [7:0]     cfg_version = 8'h20;
    logic           ent_wr = 1'b0;
    logic [SW-1:0]  ent_wsel = '0;
    logic [7:0]     ent_wvec = '0;
    logic           ent_wlevel = 1'b0;
    logic           ent_wmask = 1'b0;
    logic [NP-1:0]  rirr_set = '0;
    logic           pend_wr = 1'b0;
    logic [NP-1:0]  pend_wdata = '0;
    logic [SW-1:0]  rd_sel = '0;
    logic [7:0]     rd_vec;
    logic           rd_level, rd_mask, rd_rirr;
    logic [NP-1:0]  pend_q;
    logic           svc_now, svc_late;

    eoi_storm_ctl #(.NUM_PINS(NP), .STORM_LIMIT(LIM), .DEFER_CYCLES(DLY)) dut (
        .clk(clk), .rst_n(rst_n),
        .bc_eoi_vld(bc_eoi_vld), .bc_eoi_vec(bc_eoi_vec),
        .dir_eoi_wr(dir_eoi_wr), .dir_eoi_be(dir_eoi_be), .dir_eoi_data(dir_eoi_data),
        .cfg_version(cfg_version),
        .ent_wr(ent_wr), .ent_wsel(ent_wsel), .ent_wvec(ent_wvec),
        .ent_wlevel(ent_wlevel), .ent_wmask(ent_wmask),
        .rirr_set(rirr_set), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
        .rd_sel(rd_sel), .rd_vec(rd_vec), .rd_level(rd_level), .rd_mask(rd_mask),
        .rd_rirr(rd_rirr), .pend_q(pend_q), .svc_now(svc_now), .svc_late(svc_late)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;
    int    now_q[$];
    string now_tag[$];
    int    late_q[$];
    string late_tag[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pop expected request pulses and compare with the outputs.
    always @(negedge clk) begin
        if (mon_on) begin
            while (now_q.size() > 0 && now_q[0] < cyc) begin
                n_chk++; n_err++;
                $display("FAIL %s: svc_now actual 0 expected 1 at cycle %0d", now_tag[0], now_q[0]);
                void'(now_q.pop_front()); void'(now_tag.pop_front());
            end
            if (svc_now) begin
                n_chk++;
                if (now_q.size() > 0 && now_q[0] == cyc) begin
                    void'(now_q.pop_front()); void'(now_tag.pop_front());
                end else begin
                    n_err++;
                    $display("FAIL R4: svc_now actual 1 expected 0 at cycle %0d", cyc);
                end
            end
            while (late_q.size() > 0 && late_q[0] < cyc) begin
                n_chk++; n_err++;
                $display("FAIL %s: svc_late actual 0 expected 1 at cycle %0d", late_tag[0], late_q[0]);
                void'(late_q.pop_front()); void'(late_tag.pop_front());
            end
            if (svc_late) begin
                n_chk++;
                if (late_q.size() > 0 && late_q[0] == cyc) begin
                    void'(late_q.pop_front()); void'(late_tag.pop_front());
                end else begin
                    n_err++;
                    $display("FAIL R8: svc_late actual 1 expected 0 at cycle %0d", cyc);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic mark_rirr(logic [NP-1:0] m);
        rirr_set = m;
        step();
        rirr_set = '0;
    endtask

    // Driver: issue a broadcast acknowledge and queue the expected requests.
    task automatic bcast(logic [7:0] v, bit exp_now, bit exp_late, string tag);
        bc_eoi_vld = 1'b1;
        bc_eoi_vec = v;
        if (exp_now)  begin now_q.push_back(cyc + 1);        now_tag.push_back(tag);  end
        if (exp_late) begin late_q.push_back(cyc + 1 + DLY); late_tag.push_back(tag); end
        step();
        bc_eoi_vld = 1'b0;
    endtask

    task automatic direct(logic [3:0] be, logic [7:0] ver, logic [31:0] d, bit exp_now, string tag);
        dir_eoi_wr   = 1'b1;
        dir_eoi_be   = be;
        cfg_version  = ver;
        dir_eoi_data = d;
        if (exp_now) begin now_q.push_back(cyc + 1); now_tag.push_back(tag); end
        step();
        dir_eoi_wr  = 1'b0;
        cfg_version = 8'h20;
    endtask

    task automatic wr_entry(int pin, logic [7:0] v, bit lvl, bit msk);
        ent_wr = 1'b1; ent_wsel = SW'(pin); ent_wvec = v; ent_wlevel = lvl; ent_wmask = msk;
        step();
        ent_wr = 1'b0;
    endtask

    task automatic set_pend(logic [NP-1:0] m);
        pend_wr = 1'b1; pend_wdata = m;
        step();
        pend_wr = 1'b0;
    endtask

    task automatic rirr_is(int pin, bit exp, string tag);
        rd_sel = SW'(pin);
        #1;
        check(tag, 32'(rd_rirr), 32'(exp));
    endtask

    // Acknowledge pin 0 once after marking it in service.
    task automatic ack0(bit exp_now, bit exp_late, string tag);
        mark_rirr(4'b0001);
        bcast(8'h30, exp_now, exp_late, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        step();
        step();
        // R9: reset state
        check("R9 svc_now", 32'(svc_now), 0);
        check("R9 svc_late", 32'(svc_late), 0);
        check("R9 pend", 32'(pend_q), 0);
        rirr_is(0, 1'b0, "R9 rirr");
        rst_n = 1'b1;
        mon_on = 1'b1;
        step();

        wr_entry(0, 8'h30, 1'b1, 1'b0);
        wr_entry(1, 8'h30, 1'b0, 1'b0);
        wr_entry(2, 8'h41, 1'b1, 1'b1);
        wr_entry(3, 8'h41, 1'b1, 1'b0);
        set_pend(4'b1111);
        // R10: readback of fields and pending bits
        rd_sel = 2'd2; #1;
        check("R10 vec", 32'(rd_vec), 32'h41);
        check("R10 level", 32'(rd_level), 1);
        check("R10 mask", 32'(rd_mask), 1);
        check("R10 pend", 32'(pend_q), 32'hF);
        step();

        // R1/R2/R4: level pin cleared, edge pin with same vector untouched
        mark_rirr(4'b0011);
        bcast(8'h30, 1'b1, 1'b0, "R4");            // count 1
        rirr_is(0, 1'b0, "R2 cleared");
        rirr_is(1, 1'b1, "R1 edge pin kept");
        // R1: mismatched vector leaves the flag
        mark_rirr(4'b0001);
        bcast(8'h55, 1'b0, 1'b0, "R1");
        rirr_is(0, 1'b1, "R1 mismatch kept");
        bcast(8'h30, 1'b1, 1'b0, "R3");            // count 2

        // R6: entry write zeroes the count and keeps the flag
        mark_rirr(4'b0001);
        wr_entry(0, 8'h30, 1'b1, 1'b0);
        rirr_is(0, 1'b1, "R6 flag kept");
        bcast(8'h30, 1'b1, 1'b0, "R6");            // count 1
        ack0(1'b1, 1'b0, "R6");                     // 2
        ack0(1'b1, 1'b0, "R6");                     // 3
        // R5: reaching the limit defers
        ack0(1'b0, 1'b1, "R5");
        // R8: second storm while timer runs is dropped
        ack0(1'b1, 1'b0, "R8");
        ack0(1'b1, 1'b0, "R8");
        ack0(1'b1, 1'b0, "R8");
        ack0(1'b0, 1'b0, "R8");
        repeat (DLY + 4) step();

        // R3/R4: masked affected pin cleared, no request
        mark_rirr(4'b0100);
        bcast(8'h41, 1'b0, 1'b0, "R4 masked");
        rirr_is(2, 1'b0, "R2 masked pin cleared");
        rirr_is(3, 1'b0, "R1 pin3 untouched");

        // R3: a non-pending acknowledge zeroes the count
        ack0(1'b1, 1'b0, "R3");                     // 1
        ack0(1'b1, 1'b0, "R3");                     // 2
        set_pend(4'b1110);
        ack0(1'b0, 1'b0, "R3 not pending");         // 0
        set_pend(4'b1111);
        ack0(1'b1, 1'b0, "R3");                     // 1
        ack0(1'b1, 1'b0, "R3");                     // 2
        ack0(1'b1, 1'b0, "R3");                     // 3
        ack0(1'b0, 1'b1, "R5");                     // storm, 0
        repeat (DLY + 4) step();

        // R7: direct write gating
        mark_rirr(4'b0001);
        direct(4'b0111, 8'h20, 32'h30, 1'b0, "R7 be");
        rirr_is(0, 1'b1, "R7 partial ignored");
        direct(4'b1111, 8'h11, 32'h30, 1'b0, "R7 ver");
        rirr_is(0, 1'b1, "R7 version ignored");
        direct(4'b1111, 8'h20, 32'h130, 1'b0, "R7 upper");
        rirr_is(0, 1'b1, "R7 upper ignored");
        direct(4'b1111, 8'h20, 32'h30, 1'b1, "R7");  // 1
        rirr_is(0, 1'b0, "R7 taken");

        // R7: broadcast wins over a direct write in the same cycle
        mark_rirr(4'b0001);
        dir_eoi_wr = 1'b1; dir_eoi_be = 4'hF; dir_eoi_data = 32'h30;
        bcast(8'h55, 1'b0, 1'b0, "R7 priority");
        dir_eoi_wr = 1'b0;
        rirr_is(0, 1'b1, "R7 direct dropped");

        // R2: set and acknowledge collide, flag stays set
        rirr_set = 4'b0001;
        bcast(8'h30, 1'b1, 1'b0, "R2");             // 2
        rirr_set = '0;
        rirr_is(0, 1'b1, "R2 set wins");

        repeat (DLY + 4) step();
        check("R8 queues drained", 32'(now_q.size() + late_q.size()), 0);
        mon_on = 1'b0;
        finish_run();
    end
endmodule